// File: doc/BRIEF.md
# Symmetric Decade and Binary Clock Divider

This block divides one reference clock two ways. The decade output runs at one tenth of the clock rate with an exact 50 percent duty cycle. The binary output runs at half the clock rate. Both outputs come from registers on the same clock, so their edges line up with the clock and with each other. It is meant to derive 1/10 and 1/2 rate square waves from a conditioned reference clock.

The decade path is a 4-bit counter that steps through 3 to 12 and wraps back to 3, not through 0 to 9. Its top bit is then the waveform: low for 3 to 7 and high for 8 to 12, so no duty-correction logic is needed. The wrap is detected from the two top bits alone. The same decode catches any out-of-range count and forces it back into the loop. An enable input freezes both dividers.

Top module: `sdiv_top`

## Requirements
- R1: While rst_ni is low, div10_o and div2_o are both 0. The internal counter starts at 3.
- R2: With en_i held high, every high interval of div10_o lasts exactly 5 clock cycles.
- R3: With en_i held high, every low interval of div10_o after the first one lasts exactly 5 clock cycles.
- R4: With en_i held high, div2_o inverts on every clock edge, so each high and low interval lasts 1 cycle.
- R5: With en_i high from the release of rst_ni, div10_o first reads 1 after the 6th rising edge, and div2_o first reads 1 after the 2nd rising edge.
- R6: Every rising edge of div10_o falls on a clock edge where div2_o also rises.
- R7: Once en_i is low, both outputs keep their level from the second rising edge after the fall of en_i until en_i returns.
- R8: Asserting rst_ni during operation restarts the dividers. The latency of R5 then holds again from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable, active high |
| div10_o | output | 1 | Clock divided by 10, 50 percent duty, registered |
| div2_o | output | 1 | Clock divided by 2, registered |

## Verification
The assertions assume that en_i changes only away from the rising clock edge. They also assume that reset is applied from time zero, so the counter never starts outside 3 to 12. The bench drives en_i and rst_ni only on falling edges and holds reset low at start-up. Interval and phase checks are made only while en_i is steady high. The latency checks use a fresh reset release with enable already high.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  parameter int unsigned DEC_W    = 4;
  parameter int unsigned DEC_LOAD = 3;
  // Wrap point is the value with the two top bits set (12 for 4 bits).
  localparam int unsigned DEC_TERM = (1 << (DEC_W - 1)) + (1 << (DEC_W - 2));
  localparam int unsigned DEC_LEN  = DEC_TERM - DEC_LOAD + 1;
endpackage

// File: rtl/sdiv_decade_cnt.sv
module sdiv_decade_cnt #(
  parameter int unsigned W    = sdiv_pkg::DEC_W,
  parameter int unsigned LOAD = sdiv_pkg::DEC_LOAD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  // Two-bit decode: covers the terminal count and any state above it.
  assign wrap = cnt_q[W-1] & cnt_q[W-2];

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = wrap ? LOAD_V : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= LOAD_V;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sdiv_toggle.sv
module sdiv_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tog_q <= 1'b0;
    else if (en_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/sdiv_out_reg.sv
module sdiv_out_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic div10_o,
  output logic div2_o
);
  logic [DEC_W-1:0] cnt_q;
  logic             tog_q;
  logic [1:0]       out_q;

  sdiv_decade_cnt #(.W(DEC_W), .LOAD(DEC_LOAD)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cnt_o (cnt_q)
  );

  sdiv_toggle u_tog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tog_o (tog_q)
  );

  // Both outputs retimed by one common register stage.
  sdiv_out_reg #(.W(2)) u_oreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cnt_q[DEC_W-1], tog_q}),
    .q_o   (out_q)
  );

  assign div10_o = out_q[1];
  assign div2_o  = out_q[0];
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk
  import sdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             div10_o,
  input logic             div2_o,
  input logic [DEC_W-1:0] cnt_q
);
  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!div10_o && !div2_o));

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= DEC_W'(DEC_LOAD)) && (cnt_q <= DEC_W'(DEC_TERM)));

  // R4
  div2_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ##2 (div2_o != $past(div2_o)));

  // R6
  phase_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div10_o) |-> $rose(div2_o));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ##2 ($stable(div10_o) && $stable(div2_o)));
endmodule

bind sdiv_top sdiv_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .div10_o(div10_o),
  .div2_o (div2_o),
  .cnt_q  (cnt_q)
);

// File: tb/sdiv_top_tb.sv
module sdiv_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic div10_o, div2_o;

  int n_chk = 0;
  int n_bad = 0;

  sdiv_top u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div10_o(div10_o),
    .div2_o (div2_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 R5 R8: reset values and latency from release
  task automatic t_reset_latency(input string tag);
    int first10, first2;
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i   = 1'b1;
    @(negedge clk_i);
    check({tag, " R1 div10 in reset"}, div10_o, 0);
    check({tag, " R1 div2 in reset"}, div2_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    first10 = 0;
    first2  = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_i);
      if (div10_o && first10 == 0) first10 = k;
      if (div2_o && first2 == 0)   first2  = k;
    end
    check({tag, " R5 div10 first high edge"}, first10, 6);
    check({tag, " R5 div2 first high edge"}, first2, 2);
  endtask

  // R2 R3 R4 R6: interval widths and phase with enable high
  task automatic t_intervals(input int cycles);
    logic p10, p2;
    int run10, run2, nruns10;
    p10 = div10_o;
    p2  = div2_o;
    run10 = 0;
    run2  = 0;
    nruns10 = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i);
      run10++;
      run2++;
      if (div2_o != p2) begin
        if (k > 0) check(p2 ? "R4 div2 high width" : "R4 div2 low width", run2, 1);
        run2 = 0;
      end
      if (div10_o != p10) begin
        if (nruns10 > 0)
          check(p10 ? "R2 div10 high width" : "R3 div10 low width", run10, 5);
        if (div10_o) check("R6 div2 rises with div10", int'(div2_o && !p2), 1);
        nruns10++;
        run10 = 0;
      end
      p10 = div10_o;
      p2  = div2_o;
    end
    check("R2 div10 saw transitions", int'(nruns10 >= 10), 1);
  endtask

  // R7: outputs frozen while enable is low
  task automatic t_hold(input int gap);
    logic h10, h2;
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    h10 = div10_o;
    h2  = div2_o;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk_i);
      check("R7 div10 held", div10_o, h10);
      check("R7 div2 held", div2_o, h2);
    end
    en_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_latency("initial");
    t_intervals(120);
    t_hold(7);
    t_hold(13);
    repeat (3) @(negedge clk_i);
    t_reset_latency("R8 mid-run");
    t_intervals(60);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule